// File: doc/BRIEF.md
# Dual-View Peripheral Register Space

This block holds the peripheral register file of a small 8-bit processor and lets the core reach it in two ways. A short port view, 64 entries deep, serves the dedicated in/out and single-bit instructions. A data-space view serves ordinary loads and stores. Both views land on the same storage: a data address equals the port address plus 0x20. Above the mirrored window sits an extended region that only loads and stores can reach. A compatibility input turns that region from a sparse register set into plain RAM.

Single-bit set and clear are carried out as a read-modify-write of the whole byte. They are accepted only in the lowest 32 port addresses, as is a combinational bit test. One status register holds write-one-to-clear flags that per-bit hardware events set. Because bit operations write back the whole byte, a bit operation on that register clears every flag that reads as one. A control register has reserved upper bits, and one port address is fully reserved. Out-of-range port or bit accesses raise a strobe and touch nothing.

Top module: `dv_regspace`

## Requirements
- R1: A port access at address 0x00..0x3F reads and writes the addressed register. A port access at 0x40 or above drives `illegal` high in the same cycle, reads zero and changes no register. In particular it does not alias onto 0x00.
- R2: A data access at address D in 0x20..0x5F reaches the register at port address D-0x20. Data addresses 0x00..0x1F read zero, and writes there are ignored.
- R3: A bit operation (`bit_set`=1 sets, 0 clears bit `bit_sel`) at port address 0x00..0x1F takes effect at the next clock edge and leaves all other bits unchanged. At 0x20 or above it raises `illegal` and changes nothing.
- R4: A bit test at port address 0x00..0x1F returns bit `tst_sel` of that register on `tst_bit` in the same cycle. At 0x20 or above it raises `illegal` and returns 0.
- R5: The status register at port address 0x0C clears each bit that is written with 1. Bits written with 0 keep their value.
- R6: A high `flag_evt[i]` sets status bit i at the next edge. This wins over a write-one-to-clear of that bit in the same cycle.
- R7: A bit operation on the status register writes back the whole byte as read, with the chosen bit modified. Set therefore clears every flag that was 1. Clear leaves the chosen flag as it was and clears every other flag that was 1.
- R8: Port address 0x1E is reserved: it reads zero and ignores writes. The control register at 0x10 keeps bits 7:6 at zero whatever is written.
- R9: With `compat_mode`=0, data addresses 0x60..0x6F are read/write extended registers. 0x70..0xFF read zero and ignore writes.
- R10: With `compat_mode`=1, the whole 0x60..0xFF range behaves as read/write RAM.
- R11: When several writes arrive in one cycle, a data write wins over a port write, which wins over a bit operation.
- R12: After reset, every register, flag and extended location reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| compat_mode | input | 1 | 1: extended region acts as plain RAM |
| io_en | input | 1 | Port-view access valid |
| io_we | input | 1 | Port-view write (0 = read) |
| io_addr | input | 8 | Port-view address |
| io_wdata | input | 8 | Port-view write data |
| io_rdata | output | 8 | Port-view read data (combinational) |
| bit_en | input | 1 | Single-bit set/clear request |
| bit_set | input | 1 | 1 = set, 0 = clear |
| bit_addr | input | 8 | Port address of the bit operation |
| bit_sel | input | 3 | Bit index of the bit operation |
| tst_en | input | 1 | Bit test request |
| tst_addr | input | 8 | Port address of the bit test |
| tst_sel | input | 3 | Bit index of the bit test |
| tst_bit | output | 1 | Bit test result (combinational) |
| ds_en | input | 1 | Data-view access valid |
| ds_we | input | 1 | Data-view write (0 = read) |
| ds_addr | input | 8 | Data-view address |
| ds_wdata | input | 8 | Data-view write data |
| ds_rdata | output | 8 | Data-view read data (combinational) |
| flag_evt | input | 8 | Per-bit hardware events that set status flags |
| illegal | output | 1 | Out-of-range port, bit or test access in this cycle |

## Verification
Some rules are checked on every cycle. These are the illegal strobe for out-of-range port and bit-test addresses, zero reads from reserved locations and from the unmapped low data window, zero upper bits on the control register, and flags seen set on the cycle after their event. Other behaviour needs a written state that is read back later, so only the bench scenarios can show it. This covers the aliasing between the two views and the read-modify-write clearing of flags by bit operations. It also covers write priority, the compatibility-mode RAM, and the absence of side effects from illegal accesses.

// File: rtl/dv_pkg.sv
// Shared widths and the internal write-request record of the register space.
// Assumes an 8-bit data path and a 64-entry port view.
package dv_pkg;
    localparam int DATA_W   = 8;
    localparam int IO_IDX_W = 6;
    localparam int IO_SPAN  = 1 << IO_IDX_W;   // port-view depth
    localparam int BIT_SPAN = IO_SPAN / 2;     // bit-addressable depth
    localparam int DS_OFS   = 32;              // data view = port + offset
    localparam int SEL_W    = $clog2(DATA_W);

    typedef struct packed {
        logic                en;
        logic [IO_IDX_W-1:0] idx;
        logic [DATA_W-1:0]   val;
    } io_wr_t;
endpackage

// File: rtl/dv_view_decode.sv
// Combinational decoder for both address views. Flags the legality of port,
// bit and test accesses and maps a data address to the port window or the
// extended region. Assumes 8-bit addresses.
module dv_view_decode
    import dv_pkg::*;
#(
    parameter int EXT_BASE = 96
) (
    input  logic                io_en,
    input  logic [7:0]          io_addr,
    input  logic                bit_en,
    input  logic [7:0]          bit_addr,
    input  logic                tst_en,
    input  logic [7:0]          tst_addr,
    input  logic [7:0]          ds_addr,
    output logic                io_ok,
    output logic                bit_ok,
    output logic                tst_ok,
    output logic                ds_is_io,
    output logic [IO_IDX_W-1:0] ds_io_idx,
    output logic                ds_is_ext,
    output logic [7:0]          ds_ext_idx,
    output logic                illegal
);
    localparam logic [7:0] IO_LIM  = 8'(IO_SPAN);
    localparam logic [7:0] BIT_LIM = 8'(BIT_SPAN);
    localparam logic [7:0] DS_LO   = 8'(DS_OFS);
    localparam logic [7:0] EXT_LO  = 8'(EXT_BASE);

    logic [7:0] ds_rel;

    // Range checks and view translation.
    always_comb begin
        io_ok      = io_addr < IO_LIM;
        bit_ok     = bit_addr < BIT_LIM;
        tst_ok     = tst_addr < BIT_LIM;
        ds_rel     = ds_addr - DS_LO;
        ds_is_io   = (ds_addr >= DS_LO) && (ds_rel < IO_LIM) && (ds_addr < EXT_LO);
        ds_io_idx  = ds_rel[IO_IDX_W-1:0];
        ds_is_ext  = ds_addr >= EXT_LO;
        ds_ext_idx = ds_addr - EXT_LO;
        illegal    = (io_en && !io_ok) || (bit_en && !bit_ok) || (tst_en && !tst_ok);
    end
endmodule

// File: rtl/dv_io_bank.sv
// The 64-entry port-view register bank. One entry is a write-one-to-clear
// flag register set by hardware events, one entry has reserved upper bits,
// and one entry is fully reserved. Assumes at most one write per cycle,
// already arbitrated by the caller.
module dv_io_bank
    import dv_pkg::*;
#(
    parameter int          FLAG_IDX  = 12,
    parameter int          CTRL_IDX  = 16,
    parameter logic [7:0]  CTRL_MASK = 8'h3F,
    parameter int          RSVD_IDX  = 30
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  io_wr_t                          wr,
    input  logic [DATA_W-1:0]               flag_evt,
    output logic [IO_SPAN-1:0][DATA_W-1:0]  rd_view
);
    for (genvar i = 0; i < IO_SPAN; i++) begin : g_reg
        if (i == RSVD_IDX) begin : g_rsvd
            // Reserved slot: no storage, reads zero.
            assign rd_view[i] = '0;
        end else if (i == FLAG_IDX) begin : g_flag
            logic [DATA_W-1:0] q;
            logic [DATA_W-1:0] clr;
            // Ones in the write data clear flags; events override clears.
            always_comb clr = (wr.en && wr.idx == IO_IDX_W'(i)) ? wr.val : '0;
            // Flag register update.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= (q & ~clr) | flag_evt;
            end
            assign rd_view[i] = q;
        end else begin : g_plain
            localparam logic [DATA_W-1:0] MASK = (i == CTRL_IDX) ? CTRL_MASK : '1;
            logic [DATA_W-1:0] q;
            // Plain register; reserved bits never store a one.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    q <= '0;
                else if (wr.en && wr.idx == IO_IDX_W'(i))      q <= wr.val & MASK;
            end
            assign rd_view[i] = q;
        end
    end
endmodule

// File: rtl/dv_ext_store.sv
// Extended region behind the port window, reachable by data accesses only.
// In normal mode only the first EXT_REGS entries hold state. In
// compatibility mode every entry is read/write RAM. Both modes share one
// storage array.
module dv_ext_store
    import dv_pkg::*;
#(
    parameter int EXT_DEPTH = 160,
    parameter int EXT_REGS  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               compat,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [7:0]         rd_idx,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [7:0] DEPTH_B = 8'(EXT_DEPTH);
    localparam logic [7:0] REGS_B  = 8'(EXT_REGS);

    logic [DATA_W-1:0] mem [EXT_DEPTH];
    logic              wr_live;
    logic              rd_live;

    // Which locations exist in the current mode.
    always_comb begin
        wr_live = wr_en && (wr_idx < DEPTH_B) && (compat || wr_idx < REGS_B);
        rd_live = (rd_idx < DEPTH_B) && (compat || rd_idx < REGS_B);
        rd_data = rd_live ? mem[rd_idx] : '0;
    end

    // Storage update with full clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < EXT_DEPTH; k++) mem[k] <= '0;
        end else if (wr_live) begin
            mem[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/dv_regspace.sv
// Top of the dual-view register space. Arbitrates one write per cycle
// (data view, then port view, then bit operation), builds the
// read-modify-write value for bit operations and steers the read data of
// both views. Assumes the requester holds its inputs stable around the edge.
module dv_regspace
    import dv_pkg::*;
#(
    parameter int         FLAG_IO   = 12,
    parameter int         CTRL_IO   = 16,
    parameter logic [7:0] CTRL_MASK = 8'h3F,
    parameter int         RSVD_IO   = 30,
    parameter int         EXT_BASE  = 96,
    parameter int         EXT_REGS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              compat_mode,
    input  logic              io_en,
    input  logic              io_we,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              bit_en,
    input  logic              bit_set,
    input  logic [7:0]        bit_addr,
    input  logic [2:0]        bit_sel,
    input  logic              tst_en,
    input  logic [7:0]        tst_addr,
    input  logic [2:0]        tst_sel,
    output logic              tst_bit,
    input  logic              ds_en,
    input  logic              ds_we,
    input  logic [7:0]        ds_addr,
    input  logic [7:0]        ds_wdata,
    output logic [7:0]        ds_rdata,
    input  logic [7:0]        flag_evt,
    output logic              illegal
);
    localparam int EXT_DEPTH = 256 - EXT_BASE;

    logic                            io_ok, bit_ok, tst_ok;
    logic                            ds_is_io, ds_is_ext;
    logic [IO_IDX_W-1:0]             ds_io_idx;
    logic [7:0]                      ds_ext_idx;
    logic [IO_SPAN-1:0][DATA_W-1:0]  bank;
    logic [DATA_W-1:0]               ext_rd;
    logic [DATA_W-1:0]               bit_cur;
    logic [DATA_W-1:0]               bit_mask;
    logic                            ds_wr, io_wr, bo_wr;
    io_wr_t                          wr_req;

    dv_view_decode #(.EXT_BASE(EXT_BASE)) dec_i (
        .io_en      (io_en),
        .io_addr    (io_addr),
        .bit_en     (bit_en),
        .bit_addr   (bit_addr),
        .tst_en     (tst_en),
        .tst_addr   (tst_addr),
        .ds_addr    (ds_addr),
        .io_ok      (io_ok),
        .bit_ok     (bit_ok),
        .tst_ok     (tst_ok),
        .ds_is_io   (ds_is_io),
        .ds_io_idx  (ds_io_idx),
        .ds_is_ext  (ds_is_ext),
        .ds_ext_idx (ds_ext_idx),
        .illegal    (illegal)
    );

    // Write arbitration and read-modify-write value for bit operations.
    always_comb begin
        ds_wr    = ds_en && ds_we;
        io_wr    = !ds_wr && io_en && io_we && io_ok;
        bo_wr    = !ds_wr && !(io_en && io_we) && bit_en && bit_ok;
        bit_cur  = bank[bit_addr[IO_IDX_W-1:0]];
        bit_mask = DATA_W'(1) << bit_sel;
        wr_req   = '0;
        if (ds_wr && ds_is_io) begin
            wr_req = '{en: 1'b1, idx: ds_io_idx, val: ds_wdata};
        end else if (io_wr) begin
            wr_req = '{en: 1'b1, idx: io_addr[IO_IDX_W-1:0], val: io_wdata};
        end else if (bo_wr) begin
            wr_req = '{en: 1'b1, idx: bit_addr[IO_IDX_W-1:0],
                       val: bit_set ? (bit_cur | bit_mask) : (bit_cur & ~bit_mask)};
        end
    end

    dv_io_bank #(
        .FLAG_IDX  (FLAG_IO),
        .CTRL_IDX  (CTRL_IO),
        .CTRL_MASK (CTRL_MASK),
        .RSVD_IDX  (RSVD_IO)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_req),
        .flag_evt (flag_evt),
        .rd_view  (bank)
    );

    dv_ext_store #(.EXT_DEPTH(EXT_DEPTH), .EXT_REGS(EXT_REGS)) ext_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .compat  (compat_mode),
        .wr_en   (ds_wr && ds_is_ext),
        .wr_idx  (ds_ext_idx),
        .wr_data (ds_wdata),
        .rd_idx  (ds_ext_idx),
        .rd_data (ext_rd)
    );

    // Read steering for both views and the bit test.
    always_comb begin
        io_rdata = (io_en && io_ok) ? bank[io_addr[IO_IDX_W-1:0]] : '0;
        tst_bit  = (tst_en && tst_ok) ? bank[tst_addr[IO_IDX_W-1:0]][tst_sel] : 1'b0;
        if (ds_is_io)       ds_rdata = bank[ds_io_idx];
        else if (ds_is_ext) ds_rdata = ext_rd;
        else                ds_rdata = '0;
    end
endmodule

// File: rtl/dv_regspace_chk.sv
// Cycle-level rules of the register space, observed at the top-level ports.
module dv_regspace_chk #(
    parameter int FLAG_IO  = 12,
    parameter int CTRL_IO  = 16,
    parameter int RSVD_IO  = 30,
    parameter int EXT_BASE = 96,
    parameter int EXT_REGS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       compat_mode,
    input logic       io_en,
    input logic [7:0] io_addr,
    input logic [7:0] io_rdata,
    input logic       tst_en,
    input logic [7:0] tst_addr,
    input logic       tst_bit,
    input logic       ds_en,
    input logic [7:0] ds_addr,
    input logic [7:0] ds_rdata,
    input logic [7:0] flag_evt,
    input logic       illegal
);
    localparam logic [7:0] FLAG_A = 8'(FLAG_IO);
    localparam logic [7:0] CTRL_A = 8'(CTRL_IO);
    localparam logic [7:0] RSVD_A = 8'(RSVD_IO);
    localparam logic [7:0] EXT_HI = 8'(EXT_BASE + EXT_REGS);

    // R1
    io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && io_addr >= 8'h40) |-> (illegal && io_rdata == 8'h00));
    // R4
    tst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_en && tst_addr >= 8'h20) |-> (illegal && !tst_bit));
    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && io_addr == RSVD_A) |-> (io_rdata == 8'h00));
    // R8
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && io_addr == CTRL_A) |-> (io_rdata[7:6] == 2'b00));
    // R6
    flag_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && io_addr == FLAG_A && $past(rst_n))
            |-> ((io_rdata & $past(flag_evt)) == $past(flag_evt)));
    // R2
    ds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_en && ds_addr < 8'h20) |-> (ds_rdata == 8'h00));
    // R9
    ext_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_en && !compat_mode && ds_addr >= EXT_HI) |-> (ds_rdata == 8'h00));
endmodule

bind dv_regspace dv_regspace_chk #(
    .FLAG_IO  (FLAG_IO),
    .CTRL_IO  (CTRL_IO),
    .RSVD_IO  (RSVD_IO),
    .EXT_BASE (EXT_BASE),
    .EXT_REGS (EXT_REGS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .compat_mode (compat_mode),
    .io_en       (io_en),
    .io_addr     (io_addr),
    .io_rdata    (io_rdata),
    .tst_en      (tst_en),
    .tst_addr    (tst_addr),
    .tst_bit     (tst_bit),
    .ds_en       (ds_en),
    .ds_addr     (ds_addr),
    .ds_rdata    (ds_rdata),
    .flag_evt    (flag_evt),
    .illegal     (illegal)
);

// File: tb/dv_regspace_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// scenarios for flags, priority, compatibility mode and reset.
module dv_regspace_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       compat_mode = 1'b0;
    logic       io_en = 1'b0, io_we = 1'b0;
    logic [7:0] io_addr = '0, io_wdata = '0;
    logic [7:0] io_rdata;
    logic       bit_en = 1'b0, bit_set = 1'b0;
    logic [7:0] bit_addr = '0;
    logic [2:0] bit_sel = '0;
    logic       tst_en = 1'b0;
    logic [7:0] tst_addr = '0;
    logic [2:0] tst_sel = '0;
    logic       tst_bit;
    logic       ds_en = 1'b0, ds_we = 1'b0;
    logic [7:0] ds_addr = '0, ds_wdata = '0;
    logic [7:0] ds_rdata;
    logic [7:0] flag_evt = '0;
    logic       illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dv_regspace dut_i (.*);

    // Opcodes of the vector table.
    localparam logic [2:0] OP_IOW = 3'd0, OP_IOR = 3'd1, OP_DSW = 3'd2, OP_DSR = 3'd3,
                           OP_BST = 3'd4, OP_BCL = 3'd5, OP_TST = 3'd6;
    localparam int NV = 31;
    // {req[3:0], op[2:0], addr[7:0], sel[2:0], data[7:0], expect[7:0]}
    localparam logic [33:0] VEC [NV] = '{
        {4'd1, OP_IOW, 8'h05, 3'd0, 8'hA5, 8'h00},   // R1 write
        {4'd1, OP_IOR, 8'h05, 3'd0, 8'h00, 8'hA5},   // R1 read back
        {4'd2, OP_DSR, 8'h25, 3'd0, 8'h00, 8'hA5},   // R2 data alias
        {4'd2, OP_DSW, 8'h5F, 3'd0, 8'h3C, 8'h00},   // R2 top of window
        {4'd2, OP_IOR, 8'h3F, 3'd0, 8'h00, 8'h3C},   // R2
        {4'd1, OP_IOW, 8'h40, 3'd0, 8'hFF, 8'h00},   // R1 illegal write
        {4'd1, OP_IOR, 8'h00, 3'd0, 8'h00, 8'h00},   // R1 no alias to 0x00
        {4'd3, OP_BST, 8'h05, 3'd1, 8'h00, 8'h00},   // R3 set bit 1
        {4'd3, OP_IOR, 8'h05, 3'd0, 8'h00, 8'hA7},   // R3
        {4'd3, OP_BCL, 8'h05, 3'd7, 8'h00, 8'h00},   // R3 clear bit 7
        {4'd3, OP_IOR, 8'h05, 3'd0, 8'h00, 8'h27},   // R3
        {4'd3, OP_IOW, 8'h30, 3'd0, 8'h11, 8'h00},   // R3 setup
        {4'd3, OP_BCL, 8'h30, 3'd0, 8'h00, 8'h00},   // R3 illegal bit op
        {4'd3, OP_IOR, 8'h30, 3'd0, 8'h00, 8'h11},   // R3 unchanged
        {4'd3, OP_IOR, 8'h10, 3'd0, 8'h00, 8'h00},   // R3 no alias to 0x10
        {4'd4, OP_TST, 8'h05, 3'd2, 8'h00, 8'h01},   // R4 bit set
        {4'd4, OP_TST, 8'h05, 3'd3, 8'h00, 8'h00},   // R4 bit clear
        {4'd4, OP_TST, 8'h30, 3'd0, 8'h00, 8'h00},   // R4 illegal test
        {4'd8, OP_IOW, 8'h10, 3'd0, 8'hFF, 8'h00},   // R8 control write
        {4'd8, OP_IOR, 8'h10, 3'd0, 8'h00, 8'h3F},   // R8 bits 7:6 zero
        {4'd8, OP_BST, 8'h10, 3'd7, 8'h00, 8'h00},   // R8 bit set on reserved bit
        {4'd8, OP_IOR, 8'h10, 3'd0, 8'h00, 8'h3F},   // R8
        {4'd8, OP_IOW, 8'h1E, 3'd0, 8'hFF, 8'h00},   // R8 reserved address
        {4'd8, OP_IOR, 8'h1E, 3'd0, 8'h00, 8'h00},   // R8
        {4'd8, OP_DSR, 8'h3E, 3'd0, 8'h00, 8'h00},   // R8 via data view
        {4'd9, OP_DSW, 8'h60, 3'd0, 8'h5A, 8'h00},   // R9 extended register
        {4'd9, OP_DSR, 8'h60, 3'd0, 8'h00, 8'h5A},   // R9
        {4'd9, OP_DSW, 8'h80, 3'd0, 8'h77, 8'h00},   // R9 gap write
        {4'd9, OP_DSR, 8'h80, 3'd0, 8'h00, 8'h00},   // R9 gap reads zero
        {4'd2, OP_DSW, 8'h10, 3'd0, 8'h99, 8'h00},   // R2 low data window write
        {4'd2, OP_IOR, 8'h10, 3'd0, 8'h00, 8'h3F}    // R2 did not reach 0x10
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        io_en = 0; io_we = 0; bit_en = 0; tst_en = 0; ds_en = 0; ds_we = 0; flag_evt = '0;
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); io_en = 1; io_we = 1; io_addr = a; io_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic io_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); io_en = 1; io_we = 0; io_addr = a;
        #1 check(io_rdata, exp, req);
        idle();
    endtask

    task automatic ds_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); ds_en = 1; ds_we = 1; ds_addr = a; ds_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic ds_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); ds_en = 1; ds_we = 0; ds_addr = a;
        #1 check(ds_rdata, exp, req);
        idle();
    endtask

    task automatic bit_op(input logic s, input logic [7:0] a, input logic [2:0] b);
        @(negedge clk); bit_en = 1; bit_set = s; bit_addr = a; bit_sel = b;
        @(negedge clk); idle();
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        @(negedge clk); flag_evt = e;
        @(negedge clk); idle();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        io_read(8'h05, 8'h00, "R12");
        io_read(8'h0C, 8'h00, "R12");
        ds_read(8'h60, 8'h00, "R12");

        for (int k = 0; k < NV; k++) begin
            automatic logic [33:0] v = VEC[k];
            automatic string rq = $sformatf("R%0d", v[33:30]);
            case (v[29:27])
                OP_IOW: io_write(v[26:19], v[15:8]);
                OP_IOR: io_read(v[26:19], v[7:0], rq);
                OP_DSW: ds_write(v[26:19], v[15:8]);
                OP_DSR: ds_read(v[26:19], v[7:0], rq);
                OP_BST: bit_op(1'b1, v[26:19], v[18:16]);
                OP_BCL: bit_op(1'b0, v[26:19], v[18:16]);
                default: begin
                    @(negedge clk); tst_en = 1; tst_addr = v[26:19]; tst_sel = v[18:16];
                    #1 check({7'd0, tst_bit}, v[7:0], rq);
                    idle();
                end
            endcase
        end

        // R1 / R3 / R4 strobe at the ports
        @(negedge clk); io_en = 1; io_addr = 8'h40;
        #1 check({7'd0, illegal}, 8'h01, "R1 strobe"); idle();
        @(negedge clk); bit_en = 1; bit_addr = 8'h20;
        #1 check({7'd0, illegal}, 8'h01, "R3 strobe"); idle();
        @(negedge clk); io_en = 1; io_addr = 8'h3F;
        #1 check({7'd0, illegal}, 8'h00, "R1 legal no strobe"); idle();

        // R6 event sets flags, R5 write-one-to-clear
        pulse_evt(8'hF0);
        io_read(8'h0C, 8'hF0, "R6");
        io_write(8'h0C, 8'h00);
        io_read(8'h0C, 8'hF0, "R5 zero write");
        io_write(8'h0C, 8'h30);
        io_read(8'h0C, 8'hC0, "R5");
        // R7 clear op: chosen flag kept, others cleared
        bit_op(1'b0, 8'h0C, 3'd7);
        io_read(8'h0C, 8'h80, "R7 clear");
        pulse_evt(8'h0F);
        bit_op(1'b1, 8'h0C, 3'd4);
        io_read(8'h0C, 8'h00, "R7 set");
        // R6 event wins over same-cycle clear
        @(negedge clk); flag_evt = 8'h01; io_en = 1; io_we = 1; io_addr = 8'h0C; io_wdata = 8'hFF;
        @(negedge clk); idle();
        io_read(8'h0C, 8'h01, "R6 priority");

        // R11 data write beats port write and bit op on the same register
        @(negedge clk);
        ds_en = 1; ds_we = 1; ds_addr = 8'h25; ds_wdata = 8'h11;
        io_en = 1; io_we = 1; io_addr = 8'h05; io_wdata = 8'h22;
        bit_en = 1; bit_set = 1; bit_addr = 8'h05; bit_sel = 3'd7;
        @(negedge clk); idle();
        io_read(8'h05, 8'h11, "R11 data first");
        // R11 port write beats bit op
        @(negedge clk);
        io_en = 1; io_we = 1; io_addr = 8'h05; io_wdata = 8'h22;
        bit_en = 1; bit_set = 1; bit_addr = 8'h05; bit_sel = 3'd7;
        @(negedge clk); idle();
        io_read(8'h05, 8'h22, "R11 port over bit");

        // R10 compatibility RAM
        compat_mode = 1;
        ds_write(8'h80, 8'h77);
        ds_read(8'h80, 8'h77, "R10");
        ds_write(8'hFF, 8'h12);
        ds_read(8'hFF, 8'h12, "R10 top");
        compat_mode = 0;
        ds_read(8'h80, 8'h00, "R9 gap after mode exit");

        // R12 mid-run reset
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        io_read(8'h05, 8'h00, "R12 after reset");
        ds_read(8'h60, 8'h00, "R12 after reset");

        done = 1;
        report();
    end
endmodule